// File: doc/BRIEF.md
# Serial control-port register writer

This block is the configuration port of a larger device. A microcontroller, acting as bus master, loads a small bank of 8-bit configuration registers through three inputs: an active-low select, a bit clock and a data line. Each write transaction opens when select falls. The master then shifts in an address byte, which holds a fixed 7-bit device identity followed by a direction bit. A pointer byte comes next and names the first target register. Any number of data bytes follow, and the pointer advances after each one. Every byte is sent most significant bit first. The data line is sampled on rising edges of the bit clock.

The three pins are asynchronous to the system clock. The block brings them into the system clock domain through synchroniser chains and finds their edges there, so the bit clock must run well below the system clock. The select pin is shared with the address pin of an alternative two-wire mode. At reset the block assumes two-wire mode. The first falling edge it sees on that pin commits it to serial mode until the next reset. Every accepted register write raises a one-cycle strobe together with the written index. The register bank is also visible as one flat parallel output.

Top module: `ctlport_writer`

## Requirements
- R1: After synchronous reset, every register reads 0x00, `spi_mode` is 0 and `wr_strobe` is 0.
- R2: `spi_mode` rises only after a falling edge on `sel_n_pin` that occurs after reset, and it then stays 1 until the next reset. A pin that is held low from reset, or held high, leaves it at 0.
- R3: A transaction whose first byte is 0x20 (identity 0010000 in bits 7..1, direction bit 0 = write) goes on to write registers.
- R4: If bits 7..1 of the first byte differ from 0010000, the rest of the transaction is ignored and no register changes.
- R5: If bit 0 of the first byte is 1 (read), the rest of the transaction is ignored and no register changes.
- R6: The second byte is the register pointer. The third byte, taken MSB first, is written to register `pointer`. Register i appears on `cfg_regs[8*i+7:8*i]`.
- R7: The pointer goes up by one after each data byte, so later bytes of the same transaction fill the registers that follow.
- R8: A data byte whose current pointer is 16 or more is discarded without a strobe. This also applies to bytes that the auto-increment carries past register 15.
- R9: When select rises in the middle of a byte, that partial byte is discarded. The next transaction starts again from bit 0 of its address byte.
- R10: Each register write raises `wr_strobe` for exactly one cycle, with `wr_index` equal to the written register. No register changes without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_pin | input | 1 | Asynchronous active-low select, shared with the two-wire address pin |
| sck_pin | input | 1 | Asynchronous serial bit clock; data is taken on its rising edge |
| sdi_pin | input | 1 | Asynchronous serial data in, MSB first |
| spi_mode | output | 1 | 1 once serial mode has been committed |
| wr_strobe | output | 1 | One-cycle pulse per register write |
| wr_index | output | 4 | Index of the register written with the strobe |
| cfg_regs | output | 128 | Register bank, register i at bits 8*i+7..8*i |

## Verification
Some properties are checked on every cycle. The mode flag never falls once set, and it rises only after a detected select fall. The strobe never lasts two cycles. No strobe follows the skip or idle states. A strobe only ever carries a pointer below the bank size. The bank never changes in a cycle without a write enable. Other behaviour can only be shown by the bench's scenarios: identity matching, rejection of the read bit, MSB-first assembly, auto-increment across the end of the bank, and clean restart after an aborted byte. The bench shows these by comparing the whole bank, and the number of strobes, with a model after each transaction.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e              st;
        logic [CNT_W-1:0]        cnt;
        logic [BYTE_W-1:0]       sh;
        logic [BYTE_W-1:0]       ptr;
    } ctl_ctx_t;

    // identity sits in bits 7..1, direction bit 0 must be 0 (write)
    function automatic logic addr_byte_ok(input logic [BYTE_W-1:0] b,
                                          input logic [BYTE_W-2:0] dev);
        return (b[BYTE_W-1:1] == dev) && !b[0];
    endfunction

endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] pipe [STAGES];
    logic [WIDTH-1:0] last;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= '0;
                else     pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= '0;
        else     last <= pipe[STAGES-1];
    end

    assign level = pipe[STAGES-1];
    assign rise  = level & ~last;
    assign fall  = ~level & last;

endmodule

// File: rtl/ctlport_mode.sv
module ctlport_mode (
    input  logic clk,
    input  logic rst,
    input  logic sel_fall,
    output logic spi_mode
);

    always_ff @(posedge clk) begin
        if (rst)           spi_mode <= 1'b0;
        else if (sel_fall) spi_mode <= 1'b1;
    end

    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        spi_mode |=> spi_mode);

    a_r2_mode_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_mode) |-> $past(sel_fall));

endmodule

// File: rtl/ctlport_deser.sv
module ctlport_deser
    import ctlport_pkg::*;
#(
    parameter int                NREG     = 16,
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b0010000,
    localparam int               IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_high,
    input  logic              sel_fall,
    input  logic              sck_rise,
    input  logic              sdi,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    ctl_ctx_t          ctx;
    logic [BYTE_W-1:0] sh_next;
    logic              byte_done;
    logic              ptr_in_range;

    always_comb begin
        sh_next      = {ctx.sh[BYTE_W-2:0], sdi};
        byte_done    = sck_rise && (ctx.cnt == CNT_W'(BYTE_W - 1));
        ptr_in_range = ctx.ptr < BYTE_W'(NREG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0};
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (sel_high) begin
                ctx.st  <= ST_IDLE;
                ctx.cnt <= '0;
            end else if (sel_fall) begin
                ctx.st  <= ST_ADDR;
                ctx.cnt <= '0;
            end else if (sck_rise && ctx.st != ST_IDLE) begin
                ctx.sh  <= sh_next;
                ctx.cnt <= ctx.cnt + 1'b1;
                if (byte_done) begin
                    unique case (ctx.st)
                        ST_ADDR: ctx.st <= addr_byte_ok(sh_next, DEV_ADDR)
                                           ? ST_PTR : ST_SKIP;
                        ST_PTR: begin
                            ctx.ptr <= sh_next;
                            ctx.st  <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (ptr_in_range) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= ctx.ptr[IDX_W-1:0];
                                wr_data <= sh_next;
                            end
                            ctx.ptr <= ctx.ptr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    a_r8_strobe_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(ctx.ptr) < BYTE_W'(NREG)));

    a_r4_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (ctx.st == ST_SKIP) |=> !wr_en);

    a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (ctx.st == ST_IDLE) |=> !wr_en);

endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile #(
    parameter int  NREG  = 16,
    parameter int  DW    = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] flat
);

    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                   regs[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))     regs[i] <= wr_data;
        end
        assign flat[i*DW +: DW] = regs[i];
    end

    a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat));

endmodule

// File: rtl/ctlport_writer.sv
module ctlport_writer
    import ctlport_pkg::*;
#(
    parameter int                NREG        = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b0010000,
    localparam int               IDX_W       = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel_n_pin,
    input  logic                   sck_pin,
    input  logic                   sdi_pin,
    output logic                   spi_mode,
    output logic                   wr_strobe,
    output logic [IDX_W-1:0]       wr_index,
    output logic [NREG*BYTE_W-1:0] cfg_regs
);

    localparam int PIN_SEL = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 2;

    logic [2:0]        lvl, rise, fall;
    logic [BYTE_W-1:0] wr_data;

    ctlport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     ({sdi_pin, sck_pin, sel_n_pin}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    ctlport_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .sel_fall (fall[PIN_SEL]),
        .spi_mode (spi_mode)
    );

    ctlport_deser #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .sel_high (lvl[PIN_SEL]),
        .sel_fall (fall[PIN_SEL]),
        .sck_rise (rise[PIN_SCK]),
        .sdi      (lvl[PIN_SDI]),
        .wr_en    (wr_strobe),
        .wr_idx   (wr_index),
        .wr_data  (wr_data)
    );

    ctlport_regfile #(.NREG(NREG), .DW(BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_strobe),
        .wr_idx  (wr_index),
        .wr_data (wr_data),
        .flat    (cfg_regs)
    );

    logic unused_edges;
    assign unused_edges = ^{rise[PIN_SEL], rise[PIN_SDI], fall[PIN_SCK],
                            fall[PIN_SDI], lvl[PIN_SCK]};

endmodule

// File: tb/tb_ctlport_writer.sv
module tb_ctlport_writer;

    localparam int NREG = 16;
    localparam int HALF = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sel_n_pin = 1'b0;
    logic           sck_pin = 1'b0;
    logic           sdi_pin = 1'b0;
    logic           spi_mode;
    logic           wr_strobe;
    logic [3:0]     wr_index;
    logic [127:0]   cfg_regs;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    int double_hi = 0;
    bit done = 0;
    logic prev_strobe = 1'b0;
    logic [7:0] exp_regs [NREG];

    always #10 clk = ~clk;

    ctlport_writer dut (
        .clk(clk), .rst(rst), .sel_n_pin(sel_n_pin), .sck_pin(sck_pin),
        .sdi_pin(sdi_pin), .spi_mode(spi_mode), .wr_strobe(wr_strobe),
        .wr_index(wr_index), .cfg_regs(cfg_regs)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && wr_strobe) strobes++;
        if (!rst && wr_strobe && prev_strobe) double_hi++;
        prev_strobe <= wr_strobe;
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, 32'(cfg_regs[i*8 +: 8]), 32'(exp_regs[i]));
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi_pin = b;
        wait_cyc(HALF);
        sck_pin = 1'b1;
        wait_cyc(HALF);
        sck_pin = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) send_bit(v[k]);
    endtask

    task automatic open_tx();
        sel_n_pin = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic close_tx();
        wait_cyc(HALF);
        sel_n_pin = 1'b1;
        wait_cyc(10);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(4);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        wait_cyc(2);
    endtask

    task automatic t_reset();
        check("R1 mode after reset", 32'(spi_mode), 0);
        check("R1 strobe after reset", 32'(wr_strobe), 0);
        check_bank("R1 bank after reset");
    endtask

    task automatic t_mode_static();
        // pin held low since reset, then raised: no fall seen yet
        wait_cyc(30);
        check("R2 held low", 32'(spi_mode), 0);
        sel_n_pin = 1'b1;
        wait_cyc(30);
        check("R2 held high", 32'(spi_mode), 0);
    endtask

    task automatic t_single();
        int s0 = strobes;
        open_tx();
        send_byte(8'h20); send_byte(8'h03); send_byte(8'hA5);
        close_tx();
        exp_regs[3] = 8'hA5;
        check("R2 committed by first fall", 32'(spi_mode), 1);
        check_bank("R3 R6 single write");
        check("R10 one strobe", 32'(strobes - s0), 1);
        check("R10 strobe one cycle", 32'(double_hi), 0);
    endtask

    task automatic t_burst();
        int s0 = strobes;
        open_tx();
        send_byte(8'h20); send_byte(8'h05);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h3C);
        close_tx();
        exp_regs[5] = 8'h11; exp_regs[6] = 8'h22; exp_regs[7] = 8'h3C;
        check_bank("R7 burst");
        check("R10 burst strobes", 32'(strobes - s0), 3);
    endtask

    task automatic t_bad_addr();
        int s0 = strobes;
        open_tx();
        send_byte(8'h22); send_byte(8'h00); send_byte(8'hFF);
        close_tx();
        check_bank("R4 wrong identity");
        check("R4 no strobe", 32'(strobes - s0), 0);
    endtask

    task automatic t_read_bit();
        int s0 = strobes;
        open_tx();
        send_byte(8'h21); send_byte(8'h01); send_byte(8'h5A);
        close_tx();
        check_bank("R5 read bit set");
        check("R5 no strobe", 32'(strobes - s0), 0);
    endtask

    task automatic t_range();
        int s0 = strobes;
        open_tx();
        send_byte(8'h20); send_byte(8'h0E);
        send_byte(8'h44); send_byte(8'h55); send_byte(8'h66); send_byte(8'h77);
        close_tx();
        exp_regs[14] = 8'h44; exp_regs[15] = 8'h55;
        check_bank("R8 increment past end");
        check("R8 strobes past end", 32'(strobes - s0), 2);
        s0 = strobes;
        open_tx();
        send_byte(8'h20); send_byte(8'h40); send_byte(8'h99);
        close_tx();
        check_bank("R8 pointer out of range");
        check("R8 no strobe out of range", 32'(strobes - s0), 0);
        check("R2 mode kept", 32'(spi_mode), 1);
    endtask

    task automatic t_abort();
        int s0 = strobes;
        open_tx();
        send_byte(8'h20); send_byte(8'h07);
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        close_tx();
        check_bank("R9 partial data byte dropped");
        check("R9 no strobe on abort", 32'(strobes - s0), 0);
        open_tx();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        close_tx();
        open_tx();
        send_byte(8'h20); send_byte(8'h07); send_byte(8'hC3);
        close_tx();
        exp_regs[7] = 8'hC3;
        check_bank("R9 clean restart");
        check("R10 strobe after restart", 32'(strobes - s0), 1);
    endtask

    task automatic t_rereset();
        wait_cyc(20);
        check("R2 sticky while idle", 32'(spi_mode), 1);
        do_reset();
        check("R1 mode cleared by reset", 32'(spi_mode), 0);
        check_bank("R1 bank cleared by reset");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_mode_static();
        t_single();
        t_burst();
        t_bad_addr();
        t_read_bit();
        t_range();
        t_abort();
        t_rereset();
        check("R10 no double-cycle strobe", 32'(double_hi), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule